// File: doc/BRIEF.md
# Calibrated Sense-Current Calculator

This block sits between a command source and a current-sense ADC. On a calibrate command it runs three conversions in a fixed order: a reference-gain conversion, then the internal-path offset, then the external-path offset. It stores all three results. Calibration fails if either offset reads back equal to the gain, because the scale denominator would then be zero.

Once calibration has succeeded, a measure command takes one conversion on the internal or the external sense channel. The block then turns the raw count into a signed current with two integer divisions: first to microvolts using the stored gain and the selected offset, then to microamps using the selected sense resistance. One shared sequential divider performs both divisions.

The internal resistance comes from a sign-magnitude trim byte applied to a nominal value. The external resistance comes from a configuration input, with a default used when it is not configured. Every conversion is bounded by a timeout counted in clock cycles. Every accepted command ends with exactly one result pulse carrying a value and an error flag.

Top module: `isense_cal`

## Requirements
- R1: While reset is held and in the cycle after, `cmd_ready` is 1 and `res_valid` and `adc_req_valid` are 0.
- R2: Command op 0 (calibrate) issues ADC requests on channel codes 3, 6 and 5, in that order. Each request is a one-cycle pulse, and the next request is issued only after the response to the previous one. A successful calibration reports `res_error`=0.
- R3: Calibration reports `res_error`=1 if the channel-6 result equals the channel-3 result, and then no channel-5 request is issued. It also reports `res_error`=1 if the channel-5 result equals the channel-3 result.
- R4: Measure commands are answered with `res_error`=1 and issue no ADC request unless the most recent calibration succeeded. A failed calibration clears the calibrated state.
- R5: Op 1 measures ADC channel code 0 with the channel-6 offset and the internal resistance. Op 2 measures channel code 1 with the channel-5 offset and the external resistance. The result is trunc(trunc((raw-ofs)*17857/(gain-ofs))/rs), signed, with both divisions truncating toward zero.
- R6: The internal resistance in micro-ohms is (10000000 + s*m*15625)/1000, where m is `trim_byte`[6:0] and s is -1 when `trim_byte`[7] is 1, otherwise +1.
- R7: The external resistance is `ext_rs_uohm` when `ext_rs_cfg`=1, and 10000 otherwise. A configured value of zero makes an external measurement report `res_error`=1.
- R8: If no response arrives within 2*CONV_US*2^AVG_LOG2*CLK_HZ/10^6 cycles of a request, the command ends with `res_error`=1.
- R9: Each accepted command produces exactly one single-cycle `res_valid` pulse, and error results carry value 0. Op 3 is answered with an error and no ADC request. `cmd_ready` is 0 while a command is in progress, and commands offered then are ignored.
- R10: An ADC response that arrives while no request is outstanding is ignored. It produces no result and changes no stored calibration value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when cmd_ready is 1 |
| cmd_op | input | 2 | 0 calibrate, 1 measure internal, 2 measure external, 3 reserved |
| cmd_ready | output | 1 | Block idle and able to take a command |
| trim_byte | input | 8 | Sign-magnitude trim of the internal sense resistance |
| ext_rs_cfg | input | 1 | External resistance value is configured |
| ext_rs_uohm | input | RS_W | External sense resistance in micro-ohms |
| adc_req_valid | output | 1 | Conversion request pulse |
| adc_req_chan | output | CH_W | Channel code of the request |
| adc_rsp_valid | input | 1 | Conversion result strobe |
| adc_rsp_data | input | DATA_W | Raw conversion result |
| res_valid | output | 1 | Result pulse |
| res_error | output | 1 | Command failed |
| res_value | output | RES_W | Signed current in microamps (0 on error) |

## Verification
The assertions assume that the ADC answers each request with at most one `adc_rsp_valid` pulse, and never in the cycle of the request itself. They also assume reset is held for at least one clock edge before commands are driven. The bench's ADC model answers only after it observes a request, drops any further response until the next request, and goes silent only in the timeout test. The single stray response in the R10 test is driven while the block is idle, so no request is outstanding.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [1:0] {
    OP_CAL      = 2'd0,
    OP_MEAS_INT = 2'd1,
    OP_MEAS_EXT = 2'd2,
    OP_RSVD     = 2'd3
  } isc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_D1_GO,
    ST_D1_RUN,
    ST_D2_GO,
    ST_D2_RUN
  } isc_state_e;

  localparam int CH_GAIN         = 3;
  localparam int CH_OFS_INT      = 6;
  localparam int CH_OFS_EXT      = 5;
  localparam int CH_SNS_INT      = 0;
  localparam int CH_SNS_EXT      = 1;
  localparam int REF_UV          = 17857;
  localparam int RS_NOMINAL_UOHM = 10000;
  localparam int TRIM_MUL        = 125;  // 15625 nohm / 1000 = 125/8 uohm
endpackage

// File: rtl/isc_trim.sv
module isc_trim
  import isc_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       trim,
  output logic [OUT_W-1:0] rs_uohm
);
  logic [13:0] prod;
  logic [13:0] up_step;
  logic [13:0] dn_step;

  always_comb begin
    prod    = 14'(trim[6:0]) * 14'(TRIM_MUL);
    up_step = prod >> 3;              // floor for the positive direction
    dn_step = (prod + 14'd7) >> 3;    // ceiling for the negative direction
  end

  always_ff @(posedge clk) begin
    if (rst) rs_uohm <= OUT_W'(RS_NOMINAL_UOHM);
    else if (trim[7]) rs_uohm <= OUT_W'(RS_NOMINAL_UOHM) - OUT_W'(dn_step);
    else rs_uohm <= OUT_W'(RS_NOMINAL_UOHM) + OUT_W'(up_step);
  end
endmodule

// File: rtl/isc_timer.sv
module isc_timer #(
  parameter int unsigned LIMIT = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en && !expired) cnt <= cnt + 1'b1;
  end

  assign expired = en && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/isc_div.sv
module isc_div #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic signed [W-1:0] num,
  input  logic signed [W-1:0] den,
  output logic                done,
  output logic                dz,
  output logic signed [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  a_q, b_q, q_q;
  logic [W:0]    rem_q;
  logic [W:0]    trial;
  logic [CW-1:0] cnt_q;
  logic          busy_q, neg_q;

  always_comb trial = {rem_q[W-1:0], a_q[W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0; b_q <= '0; q_q <= '0; rem_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; neg_q <= 1'b0; done <= 1'b0; dz <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        neg_q <= num[W-1] ^ den[W-1];
        q_q   <= '0;
        rem_q <= '0;
        a_q   <= num[W-1] ? $unsigned(-num) : $unsigned(num);
        b_q   <= den[W-1] ? $unsigned(-den) : $unsigned(den);
        if (den == '0) begin
          done   <= 1'b1;
          dz     <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          dz     <= 1'b0;
          busy_q <= 1'b1;
          cnt_q  <= CW'(W);
        end
      end else if (busy_q) begin
        a_q <= a_q << 1;
        if (trial >= {1'b0, b_q}) begin
          rem_q <= trial - {1'b0, b_q};
          q_q   <= {q_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial;
          q_q   <= {q_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign quot = neg_q ? -$signed(q_q) : $signed(q_q);
endmodule

// File: rtl/isense_cal.sv
module isense_cal
  import isc_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 1_000_000,
  parameter int unsigned AVG_LOG2 = 0,
  parameter int unsigned CONV_US  = 2000,
  parameter int          DATA_W   = 16,
  parameter int          RS_W     = 24,
  parameter int          RES_W    = 32,
  parameter int          CH_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  output logic              cmd_ready,
  input  logic [7:0]        trim_byte,
  input  logic              ext_rs_cfg,
  input  logic [RS_W-1:0]   ext_rs_uohm,
  output logic              adc_req_valid,
  output logic [CH_W-1:0]   adc_req_chan,
  input  logic              adc_rsp_valid,
  input  logic [DATA_W-1:0] adc_rsp_data,
  output logic              res_valid,
  output logic              res_error,
  output logic [RES_W-1:0]  res_value
);
  localparam longint unsigned TO_CYC_L =
    ((64'(2 * CONV_US)) << AVG_LOG2) * 64'(CLK_HZ) / 64'd1_000_000;
  localparam int unsigned TO_CYC = int'(TO_CYC_L);

  isc_state_e        state;
  logic [1:0]        step;
  logic              is_cal, sel_ext, cal_ok;
  logic [CH_W-1:0]   chan;
  logic [DATA_W-1:0] gain_q, ofs_int_q, ofs_ext_q, raw_q;
  logic signed [RES_W-1:0] vs_q;

  logic [DATA_W-1:0]       ofs_sel;
  logic signed [DATA_W:0]  diff, gden;
  logic signed [RES_W-1:0] num1, rs_eff, div_num, div_den, div_quot;
  logic [RES_W-1:0]        rs_int;
  logic                    div_start, div_done, div_dz, to_exp;

  isc_trim #(.OUT_W(RES_W)) u_trim (
    .clk(clk), .rst(rst), .trim(trim_byte), .rs_uohm(rs_int)
  );

  isc_timer #(.LIMIT(TO_CYC)) u_timer (
    .clk(clk), .rst(rst), .clr(state == ST_REQ), .en(state == ST_WAIT),
    .expired(to_exp)
  );

  always_comb begin
    ofs_sel = sel_ext ? ofs_ext_q : ofs_int_q;
    diff    = $signed({1'b0, raw_q})  - $signed({1'b0, ofs_sel});
    gden    = $signed({1'b0, gain_q}) - $signed({1'b0, ofs_sel});
    num1    = RES_W'(diff) * RES_W'(REF_UV);
    if (!sel_ext)        rs_eff = $signed(rs_int);
    else if (ext_rs_cfg) rs_eff = $signed(RES_W'(ext_rs_uohm));
    else                 rs_eff = RES_W'(RS_NOMINAL_UOHM);
    div_start = (state == ST_D1_GO) || (state == ST_D2_GO);
    div_num   = (state == ST_D2_GO) ? vs_q   : num1;
    div_den   = (state == ST_D2_GO) ? rs_eff : RES_W'(gden);
  end

  isc_div #(.W(RES_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(div_den),
    .done(div_done), .dz(div_dz), .quot(div_quot)
  );

  assign cmd_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; step <= '0; is_cal <= 1'b0; sel_ext <= 1'b0;
      cal_ok <= 1'b0; chan <= '0; gain_q <= '0; ofs_int_q <= '0;
      ofs_ext_q <= '0; raw_q <= '0; vs_q <= '0;
      adc_req_valid <= 1'b0; adc_req_chan <= '0;
      res_valid <= 1'b0; res_error <= 1'b0; res_value <= '0;
    end else begin
      res_valid     <= 1'b0;
      adc_req_valid <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          case (cmd_op)
            OP_CAL: begin
              is_cal <= 1'b1; cal_ok <= 1'b0; step <= 2'd0;
              chan <= CH_W'(CH_GAIN); state <= ST_REQ;
            end
            OP_MEAS_INT, OP_MEAS_EXT: begin
              is_cal  <= 1'b0;
              sel_ext <= (cmd_op == OP_MEAS_EXT);
              chan    <= (cmd_op == OP_MEAS_EXT) ? CH_W'(CH_SNS_EXT) : CH_W'(CH_SNS_INT);
              if (cal_ok) state <= ST_REQ;
              else begin
                res_valid <= 1'b1; res_error <= 1'b1; res_value <= '0;
              end
            end
            default: begin
              res_valid <= 1'b1; res_error <= 1'b1; res_value <= '0;
            end
          endcase
        end
        ST_REQ: begin
          adc_req_valid <= 1'b1;
          adc_req_chan  <= chan;
          state         <= ST_WAIT;
        end
        ST_WAIT: begin
          if (adc_rsp_valid) begin
            if (is_cal) begin
              case (step)
                2'd0: begin
                  gain_q <= adc_rsp_data; step <= 2'd1;
                  chan <= CH_W'(CH_OFS_INT); state <= ST_REQ;
                end
                2'd1: begin
                  ofs_int_q <= adc_rsp_data;
                  if (adc_rsp_data == gain_q) begin
                    res_valid <= 1'b1; res_error <= 1'b1; res_value <= '0;
                    state <= ST_IDLE;
                  end else begin
                    step <= 2'd2; chan <= CH_W'(CH_OFS_EXT); state <= ST_REQ;
                  end
                end
                default: begin
                  ofs_ext_q <= adc_rsp_data;
                  res_valid <= 1'b1; res_value <= '0; state <= ST_IDLE;
                  if (adc_rsp_data == gain_q) res_error <= 1'b1;
                  else begin
                    res_error <= 1'b0; cal_ok <= 1'b1;
                  end
                end
              endcase
            end else begin
              raw_q <= adc_rsp_data;
              state <= ST_D1_GO;
            end
          end else if (to_exp) begin
            res_valid <= 1'b1; res_error <= 1'b1; res_value <= '0;
            state <= ST_IDLE;
          end
        end
        ST_D1_GO: state <= ST_D1_RUN;
        ST_D1_RUN: if (div_done) begin
          if (div_dz) begin
            res_valid <= 1'b1; res_error <= 1'b1; res_value <= '0;
            state <= ST_IDLE;
          end else begin
            vs_q  <= div_quot;
            state <= ST_D2_GO;
          end
        end
        ST_D2_GO: state <= ST_D2_RUN;
        ST_D2_RUN: if (div_done) begin
          res_valid <= 1'b1;
          res_error <= div_dz;
          res_value <= div_dz ? '0 : $unsigned(div_quot);
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/isc_chk.sv
module isc_chk #(
  parameter int unsigned CLK_HZ   = 1_000_000,
  parameter int unsigned AVG_LOG2 = 0,
  parameter int unsigned CONV_US  = 2000,
  parameter int          RES_W    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             adc_req_valid,
  input logic             adc_rsp_valid,
  input logic             res_valid,
  input logic             res_error,
  input logic [RES_W-1:0] res_value
);
  localparam longint unsigned TO_L =
    ((64'(2 * CONV_US)) << AVG_LOG2) * 64'(CLK_HZ) / 64'd1_000_000;

  logic        waiting;
  logic [63:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= 1'b0; wait_cnt <= '0;
    end else if (adc_req_valid) begin
      waiting <= 1'b1; wait_cnt <= 64'd1;
    end else if (adc_rsp_valid || res_valid) begin
      waiting <= 1'b0; wait_cnt <= '0;
    end else if (waiting) begin
      wait_cnt <= wait_cnt + 64'd1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (cmd_ready && !res_valid && !adc_req_valid));

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    adc_req_valid |=> !adc_req_valid);

  assert_req_busy_R2: assert property (@(posedge clk) disable iff (rst)
    adc_req_valid |-> !cmd_ready);

  assert_timeout_bound_R8: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= TO_L + 64'd2);

  assert_res_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (res_valid || !cmd_ready));

  assert_err_value_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_error) |-> (res_value == '0));
endmodule

bind isense_cal isc_chk #(
  .CLK_HZ(CLK_HZ), .AVG_LOG2(AVG_LOG2), .CONV_US(CONV_US), .RES_W(RES_W)
) u_isc_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .adc_req_valid(adc_req_valid), .adc_rsp_valid(adc_rsp_valid),
  .res_valid(res_valid), .res_error(res_error), .res_value(res_value)
);

// File: tb/tb_isense_cal.sv
module tb_isense_cal;
  localparam int CLK_PER  = 10;
  localparam int CLK_HZ   = 1_000_000;
  localparam int AVG_LOG2 = 1;
  localparam int TO_CYC   = 2 * 2000 * (1 << AVG_LOG2) * (CLK_HZ / 1_000_000);
  localparam int NV       = 9;

  localparam logic [1:0]  V_OP   [NV] = '{2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2, 2'd2, 2'd1};
  localparam logic [7:0]  V_TRIM [NV] = '{8'h00, 8'h7F, 8'hFF, 8'h83, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80};
  localparam logic        V_CFG  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [23:0] V_EXT  [NV] = '{24'd0, 24'd0, 24'd0, 24'd0, 24'd0, 24'd7, 24'd3, 24'd1, 24'd0};
  localparam logic [15:0] V_RAW  [NV] = '{16'd65535, 16'd65535, 16'd65535, 16'd50000, 16'd65535,
                                          16'd30000, 16'd0, 16'd1010, 16'd200};

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_ready;
  logic [7:0] trim_byte = 8'h00;
  logic ext_rs_cfg = 1'b0;
  logic [23:0] ext_rs_uohm = 24'd0;
  logic adc_req_valid;
  logic [3:0] adc_req_chan;
  logic adc_rsp_valid = 1'b0;
  logic [15:0] adc_rsp_data = 16'd0;
  logic res_valid, res_error;
  logic [31:0] res_value;

  int n_chk = 0, n_bad = 0, n_req = 0, n_res = 0;
  int chan_log [16];
  logic mute = 1'b0;
  int g_v = 1100, io_v = 1000, eo_v = 1010, raw_v = 0;
  logic r_err;
  longint r_val;
  int r_cyc;

  always #(CLK_PER / 2) clk = ~clk;

  isense_cal #(.CLK_HZ(CLK_HZ), .AVG_LOG2(AVG_LOG2)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .trim_byte(trim_byte), .ext_rs_cfg(ext_rs_cfg), .ext_rs_uohm(ext_rs_uohm),
    .adc_req_valid(adc_req_valid), .adc_req_chan(adc_req_chan),
    .adc_rsp_valid(adc_rsp_valid), .adc_rsp_data(adc_rsp_data),
    .res_valid(res_valid), .res_error(res_error), .res_value(res_value)
  );

  function automatic int adc_val(int ch);
    case (ch)
      3: return g_v;
      6: return io_v;
      5: return eo_v;
      default: return raw_v;
    endcase
  endfunction

  // ADC model: answers each observed request two cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (adc_req_valid) begin
        if (n_req < 16) chan_log[n_req] = int'(adc_req_chan);
        n_req++;
        if (!mute) begin
          repeat (2) @(negedge clk);
          adc_rsp_data  = 16'(adc_val(int'(adc_req_chan)));
          adc_rsp_valid = 1'b1;
          @(negedge clk);
          adc_rsp_valid = 1'b0;
        end
      end
    end
  end

  always @(negedge clk) if (res_valid) n_res++;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(logic [1:0] op);
    @(negedge clk);
    n_req = 0;
    cmd_op = op; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    r_cyc = 1;
    while (!res_valid && r_cyc < 20000) begin
      @(negedge clk);
      r_cyc++;
    end
    r_err = res_error;
    r_val = longint'($signed(res_value));
  endtask

  function automatic longint expect_i(logic [1:0] op, logic [7:0] tr, logic cfg,
                                      logic [23:0] ext, logic [15:0] raw);
    longint off, v, rs;
    off = (op == 2'd1) ? longint'(io_v) : longint'(eo_v);
    v = ((longint'(raw) - off) * 17857) / (longint'(g_v) - off);
    if (op == 2'd1) rs = (10000000 + (tr[7] ? -1 : 1) * longint'(tr[6:0]) * 15625) / 1000;
    else rs = cfg ? longint'(ext) : 10000;
    return v / rs;
  endfunction

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cmd_ready in reset", longint'(cmd_ready), 1);
    chk("R1 res_valid in reset", longint'(res_valid), 0);
    chk("R1 adc_req_valid in reset", longint'(adc_req_valid), 0);
    @(negedge clk); rst = 1'b0;

    // R4: measure before calibration
    do_cmd(2'd1);
    chk("R4 uncalibrated error", longint'(r_err), 1);
    chk("R4 uncalibrated no request", n_req, 0);

    // R9: reserved op
    do_cmd(2'd3);
    chk("R9 reserved op error", longint'(r_err), 1);
    chk("R9 reserved op no request", n_req, 0);

    // R2: calibration order
    do_cmd(2'd0);
    chk("R2 cal ok", longint'(r_err), 0);
    chk("R2 request count", n_req, 3);
    chk("R2 first channel", chan_log[0], 3);
    chk("R2 second channel", chan_log[1], 6);
    chk("R2 third channel", chan_log[2], 5);

    // R5 R6 R7: vector walk
    for (int i = 0; i < NV; i++) begin
      trim_byte = V_TRIM[i]; ext_rs_cfg = V_CFG[i]; ext_rs_uohm = V_EXT[i];
      raw_v = int'(V_RAW[i]);
      do_cmd(V_OP[i]);
      chk("R5 no error", longint'(r_err), 0);
      chk("R5 sense channel", chan_log[0], (V_OP[i] == 2'd2) ? 1 : 0);
      chk("R5/R6/R7 current", r_val, expect_i(V_OP[i], V_TRIM[i], V_CFG[i], V_EXT[i], V_RAW[i]));
    end

    // R7: configured zero external resistance
    ext_rs_cfg = 1'b1; ext_rs_uohm = 24'd0; raw_v = 30000;
    do_cmd(2'd2);
    chk("R7 zero resistance error", longint'(r_err), 1);
    ext_rs_cfg = 1'b0;

    // R10: stray response while idle
    @(negedge clk);
    n_res = 0;
    adc_rsp_data = 16'd7; adc_rsp_valid = 1'b1;
    @(negedge clk);
    adc_rsp_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 no result from stray response", n_res, 0);
    trim_byte = 8'h00; raw_v = 65535;
    do_cmd(2'd1);
    chk("R10 calibration kept", r_val, expect_i(2'd1, 8'h00, 1'b0, 24'd0, 16'd65535));

    // R9: command offered while busy is ignored
    @(negedge clk);
    n_req = 0; n_res = 0;
    cmd_op = 2'd1; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk);
    chk("R9 busy ready low", longint'(cmd_ready), 0);
    cmd_op = 2'd0; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (200) @(negedge clk);
    chk("R9 one result", n_res, 1);
    chk("R9 busy command dropped", n_req, 1);

    // R8: timeout
    mute = 1'b1;
    do_cmd(2'd1);
    mute = 1'b0;
    chk("R8 timeout error", longint'(r_err), 1);
    chk("R8 timeout not early", longint'(r_cyc >= TO_CYC), 1);
    chk("R8 timeout not late", longint'(r_cyc <= TO_CYC + 4), 1);

    // R3: degenerate calibrations
    io_v = 1100;
    do_cmd(2'd0);
    chk("R3 internal offset equal gain", longint'(r_err), 1);
    chk("R3 no external request", n_req, 2);
    do_cmd(2'd1);
    chk("R4 failed cal blocks measure", longint'(r_err), 1);
    io_v = 1000; eo_v = 1100;
    do_cmd(2'd0);
    chk("R3 external offset equal gain", longint'(r_err), 1);
    chk("R3 three requests", n_req, 3);
    eo_v = 1010;
    do_cmd(2'd0);
    chk("R2 recalibrate ok", longint'(r_err), 0);
    raw_v = 0; ext_rs_cfg = 1'b1; ext_rs_uohm = 24'd3;
    do_cmd(2'd2);
    chk("R5 negative after recal", r_val, expect_i(2'd2, 8'h00, 1'b1, 24'd3, 16'd0));

    summary();
    $finish;
  end
endmodule